// File: doc/BRIEF.md
# Indexed Effective Address Unit

This unit forms the operand address for the indexed addressing forms of a small 8-bit accumulator processor. The processor has four 16-bit pointer registers, two 8-bit accumulators and a 16-bit pair built from them. A decoder upstream hands the unit a mode code, a pointer select, the constant offsets taken from the instruction stream, the accumulators, the program counter and the current pointer values. The unit returns the effective address together with a zero flag, for instructions that load the address into a register. For auto-increment and auto-decrement forms it also returns one write of the updated pointer.

An indirect flag adds a second stage. The address computed first is used to fetch a 16-bit value over the byte-wide memory port, high byte first. That value becomes the final address. A direct form completes one cycle after `start`. An indirect form completes four cycles after `start`. While an indirect form is in progress, `busy` is high and further `start` pulses are ignored.

Top module: `idx_ea_unit`

## Requirements
- R1: Mode code 0 (zero offset) yields the selected pointer as the address, with no pointer write. The pointer select codes are 0 for X, 1 for Y, 2 for U and 3 for S. For any direct form, `done` and `ea` are valid in the cycle after `start` is sampled.
- R2: Mode code 1 adds the 8-bit constant sign-extended to 16 bits. Mode code 2 adds the 16-bit constant unchanged. Sums wrap modulo 65536.
- R3: Mode codes 3 and 4 (post-increment by 1 and by 2) give the old pointer as the address. They write back the pointer plus 1 or plus 2, with `ptr_wsel` equal to the pointer select.
- R4: Mode codes 5 and 6 (pre-decrement by 1 and by 2) lower the pointer by 1 or by 2. Both the address and the written-back pointer are the lowered value, wrapping below zero.
- R5: Mode codes 7 and 8 add accumulator A or B sign-extended to 16 bits. Mode code 9 adds the pair {A,B}, with A as the high byte, unsigned.
- R6: Mode codes 10 and 11 add the 8-bit constant (sign-extended) or the 16-bit constant to the program counter instead of a pointer. No pointer is written.
- R7: With `indirect` high, the unit reads the computed address in the cycle after `start` and the address plus 1 in the next cycle. Read data arrives one cycle after its `mem_rd` cycle. `ea` becomes {first byte, second byte}, with `done` four cycles after `start`.
- R8: Whenever `done` is high, `ea_zero` is high exactly when `ea` is 0000h.
- R9: A pointer write occurs at most once per accepted instruction, in the cycle after `start`, including for indirect forms. A `start` pulse while `busy` is high is ignored.
- R10: During and right after reset, `done`, `busy`, `mem_rd` and `ptr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing mode code |
| reg_sel | input | 2 | Pointer select (X, Y, U, S) |
| indirect | input | 1 | Add the memory-indirect stage |
| off8 | input | 8 | Short constant offset |
| off16 | input | 16 | Long constant offset |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc | input | 16 | Program counter |
| ptr_x | input | 16 | Pointer X |
| ptr_y | input | 16 | Pointer Y |
| ptr_u | input | 16 | Pointer U |
| ptr_s | input | 16 | Pointer S |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Indirect stage in progress |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| done | output | 1 | Final address valid |
| ea | output | 16 | Effective address |
| ea_zero | output | 1 | Effective address is zero |
| ptr_we | output | 1 | Pointer write enable |
| ptr_wsel | output | 2 | Pointer being written |
| ptr_wdata | output | 16 | Updated pointer value |

## Verification
The pointer write and the first indirect memory read fall in the same cycle when an auto-increment or auto-decrement form is also indirect. The bench provokes this with post-increment-by-2 indirect through U and pre-decrement-by-1 indirect through S. In that one cycle it checks that `ptr_we`, `ptr_wdata` and `mem_rd`/`mem_addr` are all present. The read address must be the old pointer for the increment case and the lowered pointer for the decrement case. During the increment case the bench also fires a second `start` and confirms that no extra pointer write and no change to the final address results.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [3:0] {
    EA_ZERO  = 4'd0,
    EA_OFF8  = 4'd1,
    EA_OFF16 = 4'd2,
    EA_INC1  = 4'd3,
    EA_INC2  = 4'd4,
    EA_DEC1  = 4'd5,
    EA_DEC2  = 4'd6,
    EA_ACCA  = 4'd7,
    EA_ACCB  = 4'd8,
    EA_ACCD  = 4'd9,
    EA_PC8   = 4'd10,
    EA_PC16  = 4'd11
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDHI = 2'd1,
    ST_RDLO = 2'd2,
    ST_LAST = 2'd3
  } ea_state_e;

endpackage

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int NPTR = 4
) (
  input  logic [3:0]              mode,
  input  logic [$clog2(NPTR)-1:0] reg_sel,
  input  logic [DW-1:0]           off8,
  input  logic [AW-1:0]           off16,
  input  logic [DW-1:0]           acc_a,
  input  logic [DW-1:0]           acc_b,
  input  logic [AW-1:0]           pc,
  input  logic [NPTR*AW-1:0]      ptr_flat,
  output logic [AW-1:0]           base_addr,
  output logic                    wb_en,
  output logic [AW-1:0]           wb_data
);

  localparam int EXT = AW - DW;

  logic [AW-1:0] ptrs [NPTR];
  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] base_reg;
  logic [AW-1:0] offset;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    assign ptrs[gi] = ptr_flat[gi*AW +: AW];
  end

  assign cur_ptr = ptrs[reg_sel];

  function automatic logic [AW-1:0] sext(input logic [DW-1:0] v);
    return {{EXT{v[DW-1]}}, v};
  endfunction

  always_comb begin
    base_reg = cur_ptr;
    offset   = '0;
    wb_en    = 1'b0;
    wb_data  = cur_ptr;
    case (ea_mode_e'(mode))
      EA_OFF8:  offset = sext(off8);
      EA_OFF16: offset = off16;
      EA_INC1: begin
        wb_en   = 1'b1;
        wb_data = cur_ptr + AW'(1);
      end
      EA_INC2: begin
        wb_en   = 1'b1;
        wb_data = cur_ptr + AW'(2);
      end
      EA_DEC1: begin
        offset  = '1;
        wb_en   = 1'b1;
        wb_data = cur_ptr - AW'(1);
      end
      EA_DEC2: begin
        offset  = {{(AW-1){1'b1}}, 1'b0};
        wb_en   = 1'b1;
        wb_data = cur_ptr - AW'(2);
      end
      EA_ACCA:  offset = sext(acc_a);
      EA_ACCB:  offset = sext(acc_b);
      EA_ACCD:  offset = {acc_a, acc_b};
      EA_PC8: begin
        base_reg = pc;
        offset   = sext(off8);
      end
      EA_PC16: begin
        base_reg = pc;
        offset   = off16;
      end
      default:  offset = '0;
    endcase
    base_addr = base_reg + offset;
  end

endmodule

// File: rtl/idx_ea_seq.sv
module idx_ea_seq
  import idx_ea_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          indirect,
  input  logic [SW-1:0] reg_sel,
  input  logic [AW-1:0] base_addr,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          ea_zero,
  output logic          ptr_we,
  output logic [SW-1:0] ptr_wsel,
  output logic [AW-1:0] ptr_wdata
);

  ea_state_e     state_q, state_d;
  logic [AW-1:0] base_q, base_d;
  logic [DW-1:0] hi_q, hi_d;
  logic [AW-1:0] ea_q, ea_d;
  logic          zero_q, zero_d;
  logic          done_q, done_d;
  logic          we_q, we_d;
  logic [SW-1:0] wsel_q, wsel_d;
  logic [AW-1:0] wdata_q, wdata_d;
  logic          accept;
  logic [AW-1:0] fetched;

  assign accept  = start && (state_q == ST_IDLE);
  assign fetched = {hi_q, mem_rdata};

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    hi_d    = hi_q;
    ea_d    = ea_q;
    zero_d  = zero_q;
    done_d  = 1'b0;
    we_d    = 1'b0;
    wsel_d  = wsel_q;
    wdata_d = wdata_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          we_d    = wb_en;
          wsel_d  = reg_sel;
          wdata_d = wb_data;
          if (indirect) begin
            base_d  = base_addr;
            state_d = ST_RDHI;
          end else begin
            ea_d   = base_addr;
            zero_d = (base_addr == '0);
            done_d = 1'b1;
          end
        end
      end
      ST_RDHI: state_d = ST_RDLO;
      ST_RDLO: begin
        hi_d    = mem_rdata;
        state_d = ST_LAST;
      end
      ST_LAST: begin
        ea_d    = fetched;
        zero_d  = (fetched == '0);
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      hi_q    <= '0;
      ea_q    <= '0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      wsel_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      hi_q    <= hi_d;
      ea_q    <= ea_d;
      zero_q  <= zero_d;
      done_q  <= done_d;
      we_q    <= we_d;
      wsel_q  <= wsel_d;
      wdata_q <= wdata_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_rd    = (state_q == ST_RDHI) || (state_q == ST_RDLO);
  assign mem_addr  = (state_q == ST_RDLO) ? base_q + AW'(1) : base_q;
  assign done      = done_q;
  assign ea        = ea_q;
  assign ea_zero   = zero_q;
  assign ptr_we    = we_q;
  assign ptr_wsel  = wsel_q;
  assign ptr_wdata = wdata_q;

  // R7
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> (mem_rd && mem_addr == $past(mem_addr) + AW'(1)));

  // R7
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  // R9
  wb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> ($past(start) && !$past(busy)));

  // R3
  wb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> (ptr_wsel == $past(reg_sel)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ea_zero == (ea == '0)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    reg_sel,
  input  logic          indirect,
  input  logic [DW-1:0] off8,
  input  logic [AW-1:0] off16,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_u,
  input  logic [AW-1:0] ptr_s,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          ea_zero,
  output logic          ptr_we,
  output logic [1:0]    ptr_wsel,
  output logic [AW-1:0] ptr_wdata
);

  localparam int NPTR = 4;

  logic [NPTR*AW-1:0] ptr_flat;
  logic [AW-1:0]      base_addr;
  logic               wb_en;
  logic [AW-1:0]      wb_data;

  assign ptr_flat = {ptr_s, ptr_u, ptr_y, ptr_x};

  idx_ea_calc #(.DW(DW), .AW(AW), .NPTR(NPTR)) u_calc (
    .mode      (mode),
    .reg_sel   (reg_sel),
    .off8      (off8),
    .off16     (off16),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .pc        (pc),
    .ptr_flat  (ptr_flat),
    .base_addr (base_addr),
    .wb_en     (wb_en),
    .wb_data   (wb_data)
  );

  idx_ea_seq #(.DW(DW), .AW(AW), .SW(2)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .indirect  (indirect),
    .reg_sel   (reg_sel),
    .base_addr (base_addr),
    .wb_en     (wb_en),
    .wb_data   (wb_data),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .done      (done),
    .ea        (ea),
    .ea_zero   (ea_zero),
    .ptr_we    (ptr_we),
    .ptr_wsel  (ptr_wsel),
    .ptr_wdata (ptr_wdata)
  );

endmodule

// File: tb/idx_ea_unit_test.sv
module idx_ea_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  sel;
    logic [7:0]  o8;
    logic [15:0] o16;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] exp_ea;
    logic        exp_we;
    logic [15:0] exp_wd;
  } vec_t;

  // X=1000 Y=FFFF U=8000 S=0001 PC=1234
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  2'd0, 8'h00, 16'h0000, 8'h00, 8'h00, 16'h1000, 1'b0, 16'h0000}, // R1
    '{4'd1,  2'd1, 8'h02, 16'h0000, 8'h00, 8'h00, 16'h0001, 1'b0, 16'h0000}, // R2 wrap
    '{4'd1,  2'd0, 8'h80, 16'h0000, 8'h00, 8'h00, 16'h0F80, 1'b0, 16'h0000}, // R2 neg
    '{4'd2,  2'd2, 8'h00, 16'h9000, 8'h00, 8'h00, 16'h1000, 1'b0, 16'h0000}, // R2 long
    '{4'd3,  2'd3, 8'h00, 16'h0000, 8'h00, 8'h00, 16'h0001, 1'b1, 16'h0002}, // R3
    '{4'd4,  2'd1, 8'h00, 16'h0000, 8'h00, 8'h00, 16'hFFFF, 1'b1, 16'h0001}, // R3
    '{4'd5,  2'd3, 8'h00, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0000}, // R4
    '{4'd6,  2'd0, 8'h00, 16'h0000, 8'h00, 8'h00, 16'h0FFE, 1'b1, 16'h0FFE}, // R4
    '{4'd7,  2'd0, 8'h00, 16'h0000, 8'hFF, 8'h10, 16'h0FFF, 1'b0, 16'h0000}, // R5
    '{4'd8,  2'd2, 8'h00, 16'h0000, 8'hFF, 8'h7F, 16'h807F, 1'b0, 16'h0000}, // R5
    '{4'd9,  2'd0, 8'h00, 16'h0000, 8'hF0, 8'h00, 16'h0000, 1'b0, 16'h0000}, // R5
    '{4'd10, 2'd0, 8'hFE, 16'h0000, 8'h00, 8'h00, 16'h1232, 1'b0, 16'h0000}, // R6
    '{4'd11, 2'd0, 8'h00, 16'hEDCC, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000}, // R6
    '{4'd1,  2'd0, 8'h7F, 16'h0000, 8'h00, 8'h00, 16'h107F, 1'b0, 16'h0000}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  reg_sel = '0;
  logic        indirect = 1'b0;
  logic [7:0]  off8 = '0;
  logic [15:0] off16 = '0;
  logic [7:0]  acc_a = '0;
  logic [7:0]  acc_b = '0;
  logic [15:0] pc = 16'h1234;
  logic [15:0] ptr_x = 16'h1000;
  logic [15:0] ptr_y = 16'hFFFF;
  logic [15:0] ptr_u = 16'h8000;
  logic [15:0] ptr_s = 16'h0001;
  logic [7:0]  mem_rdata = '0;
  logic        busy, mem_rd, done, ea_zero, ptr_we;
  logic [15:0] mem_addr, ea, ptr_wdata;
  logic [1:0]  ptr_wsel;

  int n_tests = 0;
  int n_fail = 0;
  int we_count = 0;
  bit finished = 1'b0;

  idx_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
    .indirect(indirect), .off8(off8), .off16(off16), .acc_a(acc_a),
    .acc_b(acc_b), .pc(pc), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_u(ptr_u),
    .ptr_s(ptr_s), .mem_rdata(mem_rdata), .busy(busy), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .done(done), .ea(ea), .ea_zero(ea_zero),
    .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wdata(ptr_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] addr);
    return addr[7:0] ^ addr[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);
  always @(negedge clk) if (ptr_we) we_count <= we_count + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic ind,
                       input logic [7:0] o8, input logic [15:0] o16,
                       input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    mode = m; reg_sel = s; indirect = ind; off8 = o8; off16 = o16;
    acc_a = a; acc_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R10 reset state
    check(!done && !busy && !mem_rd && !ptr_we, "R10 reset outputs",
          {28'd0, done, busy, mem_rd, ptr_we}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !busy && !mem_rd && !ptr_we, "R10 after release",
          {28'd0, done, busy, mem_rd, ptr_we}, 32'd0);

    // direct vectors: R1..R6, R8
    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].mode, VECS[i].sel, 1'b0, VECS[i].o8, VECS[i].o16,
            VECS[i].a, VECS[i].b);
      check(done && ea == VECS[i].exp_ea, "R1-direct ea R2 R3 R4 R5 R6",
            {16'd0, ea}, {16'd0, VECS[i].exp_ea});
      check(ea_zero == (VECS[i].exp_ea == 16'h0000), "R8 zero flag",
            {31'd0, ea_zero}, {31'd0, VECS[i].exp_ea == 16'h0000});
      check(ptr_we == VECS[i].exp_we, "R9 write enable",
            {31'd0, ptr_we}, {31'd0, VECS[i].exp_we});
      if (VECS[i].exp_we)
        check(ptr_wdata == VECS[i].exp_wd && ptr_wsel == VECS[i].sel,
              "R3 R4 writeback", {14'd0, ptr_wsel, ptr_wdata},
              {14'd0, VECS[i].sel, VECS[i].exp_wd});
    end

    // R7 indirect with 8-bit offset from X: base 1010 -> 3C3D
    issue(4'd1, 2'd0, 1'b1, 8'h10, 16'h0, 8'h0, 8'h0);
    check(mem_rd && mem_addr == 16'h1010 && busy && !done && !ptr_we,
          "R7 first read", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h1010});
    @(negedge clk);
    check(mem_rd && mem_addr == 16'h1011, "R7 second read",
          {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h1011});
    @(negedge clk);
    check(!mem_rd && !done, "R7 read gap", {30'd0, mem_rd, done}, 32'd0);
    @(negedge clk);
    check(done && ea == 16'h3C3D && !ea_zero && !busy, "R7 indirect ea",
          {16'd0, ea}, 32'h3C3D);

    // R9 post-inc by 2 on U, indirect, with a start while busy
    we_count = 0;
    issue(4'd4, 2'd2, 1'b1, 8'h00, 16'h0, 8'h0, 8'h0);
    check(ptr_we && ptr_wdata == 16'h8002 && ptr_wsel == 2'd2,
          "R3 wb during indirect", {16'd0, ptr_wdata}, 32'h8002);
    check(mem_rd && mem_addr == 16'h8000, "R7 read uses old pointer",
          {16'd0, mem_addr}, 32'h8000);
    issue(4'd0, 2'd0, 1'b0, 8'h00, 16'h0, 8'h0, 8'h0);
    check(!ptr_we && !done, "R9 start while busy ignored",
          {30'd0, ptr_we, done}, 32'd0);
    @(negedge clk);
    check(done && ea == 16'hBCBD, "R9 R7 indirect ea after busy start",
          {16'd0, ea}, 32'hBCBD);
    @(negedge clk);
    check(!done && !busy && we_count == 1, "R9 single write",
          we_count, 32'd1);

    // R4 pre-dec by 1 on S, indirect: read at 0000 -> 3C3D
    issue(4'd5, 2'd3, 1'b1, 8'h00, 16'h0, 8'h0, 8'h0);
    check(ptr_we && ptr_wdata == 16'h0000 && mem_rd && mem_addr == 16'h0000,
          "R4 lowered pointer read", {16'd0, mem_addr}, 32'h0000);
    repeat (3) @(negedge clk);
    check(done && ea == 16'h3C3D, "R4 R7 predec indirect ea",
          {16'd0, ea}, 32'h3C3D);

    finish_run();
  end

endmodule